// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync-Error Handling

This block drives the transmit side of a synchronous serial port. A host loads words into a holding register. A frame-sync input, sampled on the transmit clock, starts a frame. At every word boundary of the frame, the holding register is copied into a shift register. The shift register then sends its bits, most significant first, one per clock on a single data line. An output-enable line marks the clocks that carry data.

A frame is built from one phase or from two phases, and each phase has its own word-count field. A two-bit delay code places zero, one or two idle clocks between the frame sync and the first bit.

A frame sync can arrive while a frame is still being sent. A mode input selects how the block responds. In one mode it drops the frame, restarts from the holding register and raises a sticky error flag. In the other mode it keeps sending as if the sync had not arrived. A status bit shows whether the holding register has been consumed, which tells the host whether a restart will repeat the old word.

Top module: `sertx_frame_tx`

## Requirements
- R1: After reset, tx_oe and tx_dout are 0, hold_empty is 1 and sync_err is 0.
- R2: Each word goes out as DATA_W bits on consecutive clocks, most significant bit first. tx_oe is 1 on exactly those clocks. tx_dout is 0 whenever tx_oe is 0, which covers idle time and delay clocks.
- R3: Suppose fs_in is high at a clock edge while the block is idle. The first data bit then appears on the clock after that edge when cfg_delay is 0. It appears one clock later for code 1 and two clocks later for code 2. The reserved code 3 behaves like code 2.
- R4: With cfg_dual = 0, a frame carries cfg_len1 + 1 words. Each word after the first is copied from the holding register at the edge where the previous word's last bit ends.
- R5: With cfg_dual = 1, a frame carries (cfg_len1 + 1) + (cfg_len2 + 1) words with no gap between the two phases.
- R6: hold_empty becomes 1 at every copy into the shift register and becomes 0 at a host_wr. If both happen at the same edge, host_wr wins.
- R7: Any fs_in edge while a frame is in delay or shift counts as unexpected, except at the edge that ends the frame's last bit. With cfg_ignore_fs = 0, an unexpected fs_in drops the current word and restarts the frame from the start. The restart uses the holding register, data written since the last copy included, and sets sync_err.
- R8: If no host_wr took place since the last copy, such a restart sends the same word again.
- R9: With cfg_ignore_fs = 1, an unexpected fs_in changes neither the data stream nor sync_err.
- R10: sync_err stays 1 until a host_err_clr pulse clears it. A new error at the same edge wins over the clear.
- R11: An fs_in at the edge that ends a frame's last bit starts the next frame without an idle gap and without setting sync_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_delay | input | 2 | Idle clocks between frame sync and first bit (3 acts as 2) |
| cfg_dual | input | 1 | 1 selects a two-phase frame |
| cfg_len1 | input | LEN_W | Words in phase one, minus one |
| cfg_len2 | input | LEN_W | Words in phase two, minus one |
| cfg_ignore_fs | input | 1 | 1 ignores frame syncs that arrive mid-frame |
| host_wr | input | 1 | Write strobe for the holding register |
| host_wdata | input | DATA_W | Word written into the holding register |
| host_err_clr | input | 1 | Clears sync_err |
| fs_in | input | 1 | Frame-sync pulse |
| tx_dout | output | 1 | Serial data out |
| tx_oe | output | 1 | High on clocks that carry a data bit |
| hold_empty | output | 1 | Holding register copied and not yet rewritten |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |

## Verification
Single-word frames are run with each delay code, including the reserved one, to tell the first-bit position apart for each code. Multi-word frames check that each word comes from the holding register at its own boundary, and that the second phase follows the first with no gap. A second frame sync placed mid-word is sent three ways: with a fresh write before it, without one, and with the ignore mode set. This separates a restart with new data from a repeat of the old word and from an uninterrupted stream. A frame sync placed exactly on the last bit shows that a back-to-back frame starts cleanly with no error.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    // reserved delay code 3 is treated as the longest legal delay
    function automatic logic [1:0] eff_delay(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.empty = 1'b1;
        end
        // host write has priority over the consume marker
        if (wr_en) begin
            hold_d.data  = wr_data;
            hold_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '{data: '0, empty: 1'b1};
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_data = hold_q.data;
    assign empty     = hold_q.empty;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              msb
);

    logic [DATA_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = load_data;
        end else if (shift) begin
            sr_d = {sr_q[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb = sr_q[DATA_W-1];

endmodule

// File: rtl/sertx_stickyflag.sv
module sertx_stickyflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) begin
            flag_d = 1'b0;
        end
        if (set) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/sertx_frame_tx.sv
module sertx_frame_tx
    import sertx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_delay,
    input  logic              cfg_dual,
    input  logic [LEN_W-1:0]  cfg_len1,
    input  logic [LEN_W-1:0]  cfg_len2,
    input  logic              cfg_ignore_fs,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_err_clr,
    input  logic              fs_in,
    output logic              tx_dout,
    output logic              tx_oe,
    output logic              hold_empty,
    output logic              sync_err
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [1:0]        dly;
        logic [CNT_W-1:0]  bits;
        logic [LEN_W-1:0]  words;
        logic              phase;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              last_bit;
    logic              last_word;
    logic              frame_end;
    logic              busy;
    logic              fs_unexp;
    logic              start;
    logic              err_set;
    logic              word_load;
    logic              do_shift;
    logic [1:0]        dly_code;
    logic [LEN_W-1:0]  word_lim;
    logic [DATA_W-1:0] hold_data;
    logic              sr_msb;

    always_comb begin
        dly_code  = eff_delay(cfg_delay);
        word_lim  = ctl_q.phase ? cfg_len2 : cfg_len1;
        busy      = (ctl_q.state != ST_IDLE);
        last_bit  = (ctl_q.bits == BIT_LAST);
        last_word = (ctl_q.phase == cfg_dual) && (ctl_q.words == word_lim);
        frame_end = (ctl_q.state == ST_SHIFT) && last_bit && last_word;
        fs_unexp  = fs_in && busy && !frame_end;
        err_set   = fs_unexp && !cfg_ignore_fs;
        start     = fs_in && (!busy || frame_end || err_set);
        word_load = start || ((ctl_q.state == ST_SHIFT) && last_bit && !last_word);
        do_shift  = (ctl_q.state == ST_SHIFT) && !last_bit;

        ctl_d = ctl_q;
        if (start) begin
            ctl_d.state = (dly_code == 2'd0) ? ST_SHIFT : ST_DELAY;
            ctl_d.dly   = dly_code - 2'd1;
            ctl_d.bits  = '0;
            ctl_d.words = '0;
            ctl_d.phase = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_DELAY: begin
                    if (ctl_q.dly == 2'd0) begin
                        ctl_d.state = ST_SHIFT;
                    end else begin
                        ctl_d.dly = ctl_q.dly - 2'd1;
                    end
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        ctl_d.bits = '0;
                        if (last_word) begin
                            ctl_d.state = ST_IDLE;
                        end else if (ctl_q.words == word_lim) begin
                            ctl_d.phase = 1'b1;
                            ctl_d.words = '0;
                        end else begin
                            ctl_d.words = ctl_q.words + 1'b1;
                        end
                    end else begin
                        ctl_d.bits = ctl_q.bits + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, dly: '0, bits: '0, words: '0, phase: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sertx_holdreg #(.DATA_W(DATA_W)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .wr_data   (host_wdata),
        .take      (word_load),
        .hold_data (hold_data),
        .empty     (hold_empty)
    );

    sertx_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (word_load),
        .load_data (hold_data),
        .shift     (do_shift),
        .msb       (sr_msb)
    );

    sertx_stickyflag i_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (host_err_clr),
        .flag  (sync_err)
    );

    assign tx_oe   = (ctl_q.state == ST_SHIFT);
    assign tx_dout = tx_oe & sr_msb;

endmodule

// File: rtl/sertx_frame_tx_chk.sv
module sertx_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_ignore_fs,
    input logic host_wr,
    input logic host_err_clr,
    input logic fs_in,
    input logic tx_dout,
    input logic tx_oe,
    input logic hold_empty,
    input logic sync_err
);

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_dout); // R2

    AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> !hold_empty); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> $past(fs_in)); // R7

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> !$past(cfg_ignore_fs)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err && !host_err_clr |=> sync_err); // R10

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_clr && !fs_in |=> !sync_err); // R10

endmodule

bind sertx_frame_tx sertx_frame_tx_chk i_chk (.*);

// File: tb/test_sertx_frame_tx.sv
module test_sertx_frame_tx;

    localparam int W = 8;
    localparam int NLOG = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cfg_delay = 2'd0;
    logic         cfg_dual = 1'b0;
    logic [6:0]   cfg_len1 = 7'd0;
    logic [6:0]   cfg_len2 = 7'd0;
    logic         cfg_ignore_fs = 1'b0;
    logic         host_wr = 1'b0;
    logic [W-1:0] host_wdata = '0;
    logic         host_err_clr = 1'b0;
    logic         fs_in = 1'b0;
    logic         tx_dout, tx_oe, hold_empty, sync_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int idx = 0;

    logic lg_oe [NLOG];
    logic lg_do [NLOG];
    logic lg_er [NLOG];
    logic lg_he [NLOG];
    logic ex_oe [NLOG];
    logic ex_do [NLOG];

    always #5 clk = ~clk;

    sertx_frame_tx #(.DATA_W(W), .LEN_W(7)) i_sertx_frame_tx (
        .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_delay), .cfg_dual(cfg_dual),
        .cfg_len1(cfg_len1), .cfg_len2(cfg_len2), .cfg_ignore_fs(cfg_ignore_fs),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_err_clr(host_err_clr),
        .fs_in(fs_in), .tx_dout(tx_dout), .tx_oe(tx_oe),
        .hold_empty(hold_empty), .sync_err(sync_err)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // sample outputs of the previous edge, then drive inputs for the next edge
    task automatic step(input logic fs, input logic wr, input logic [W-1:0] d, input logic clr);
        @(negedge clk);
        lg_oe[idx] = tx_oe;
        lg_do[idx] = tx_dout;
        lg_er[idx] = sync_err;
        lg_he[idx] = hold_empty;
        idx++;
        fs_in = fs;
        host_wr = wr;
        host_wdata = d;
        host_err_clr = clr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic begin_scn();
        idle(3);
        idx = 0;
        for (int i = 0; i < NLOG; i++) begin
            ex_oe[i] = 1'b0;
            ex_do[i] = 1'b0;
        end
    endtask

    task automatic exp_word(input int at, input logic [W-1:0] d);
        for (int b = 0; b < W; b++) begin
            ex_oe[at + b] = 1'b1;
            ex_do[at + b] = d[W-1-b];
        end
    endtask

    task automatic check_stream(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            chk(tag, $sformatf("tx_oe[%0d]", i), lg_oe[i], ex_oe[i]);
            chk(tag, $sformatf("tx_dout[%0d]", i), lg_do[i], ex_do[i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "tx_oe", tx_oe, 1'b0);
        chk("R1", "tx_dout", tx_dout, 1'b0);
        chk("R1", "hold_empty", hold_empty, 1'b1);
        chk("R1", "sync_err", sync_err, 1'b0);
    endtask

    // R2 / R3 / R6: one word with a given delay code
    task automatic t_delay(input logic [1:0] code, input int d, input logic [W-1:0] v, input string tag);
        cfg_delay = code;
        cfg_len1 = 7'd0;
        begin_scn();
        step(1'b0, 1'b1, v, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        idle(12);
        exp_word(2 + d, v);
        check_stream(tag, 14);
        chk("R6", "hold_empty after write", lg_he[1], 1'b0);
        chk("R6", "hold_empty after copy", lg_he[2], 1'b1);
        cfg_delay = 2'd0;
    endtask

    task automatic t_single_phase();
        cfg_len1 = 7'd2;
        begin_scn();
        step(1'b0, 1'b1, 8'h3C, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        idle(2);
        step(1'b0, 1'b1, 8'hE1, 1'b0);        // step 4
        idle(7);
        step(1'b0, 1'b1, 8'h96, 1'b0);        // step 12
        idle(15);
        exp_word(2, 8'h3C);
        exp_word(10, 8'hE1);
        exp_word(18, 8'h96);
        check_stream("R4", 28);
        chk("R6", "hold_empty after mid-frame write", lg_he[5], 1'b0);
        chk("R6", "hold_empty after word copy", lg_he[10], 1'b1);
        cfg_len1 = 7'd0;
    endtask

    task automatic t_dual_phase();
        cfg_dual = 1'b1;
        cfg_len1 = 7'd0;
        cfg_len2 = 7'd1;
        begin_scn();
        step(1'b0, 1'b1, 8'hB2, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        idle(28);
        exp_word(2, 8'hB2);
        exp_word(10, 8'hB2);
        exp_word(18, 8'hB2);
        check_stream("R5", 30);
        cfg_dual = 1'b0;
        cfg_len2 = 7'd0;
    endtask

    task automatic t_abort(input logic with_wr);
        logic [W-1:0] second;
        second = with_wr ? 8'h5E : 8'hC3;
        cfg_len1 = 7'd1;
        cfg_ignore_fs = 1'b0;
        begin_scn();
        step(1'b0, 1'b1, 8'hC3, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        idle(1);
        step(1'b0, with_wr, 8'h5E, 1'b0);     // step 3
        idle(1);
        step(1'b1, 1'b0, '0, 1'b0);           // step 5: unexpected sync
        idle(18);
        exp_word(2, 8'hC3);
        exp_word(6, second);
        exp_word(14, second);
        if (with_wr) begin
            check_stream("R7", 24);
            chk("R7", "sync_err before", lg_er[5], 1'b0);
            chk("R7", "sync_err after", lg_er[6], 1'b1);
        end else begin
            check_stream("R8", 24);
            chk("R8", "sync_err after", lg_er[6], 1'b1);
        end
        chk("R10", "sync_err held", lg_er[23], 1'b1);
        step(1'b0, 1'b0, '0, 1'b1);
        step(1'b0, 1'b0, '0, 1'b0);
        chk("R10", "sync_err cleared", lg_er[25], 1'b0);
        cfg_len1 = 7'd0;
    endtask

    task automatic t_ignore();
        cfg_len1 = 7'd1;
        cfg_ignore_fs = 1'b1;
        begin_scn();
        step(1'b0, 1'b1, 8'h71, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        idle(3);
        step(1'b1, 1'b0, '0, 1'b0);           // step 5: ignored
        idle(16);
        exp_word(2, 8'h71);
        exp_word(10, 8'h71);
        check_stream("R9", 22);
        chk("R9", "sync_err stays", lg_er[7], 1'b0);
        chk("R9", "sync_err end", lg_er[21], 1'b0);
        cfg_ignore_fs = 1'b0;
        cfg_len1 = 7'd0;
    endtask

    task automatic t_back_to_back();
        cfg_len1 = 7'd0;
        begin_scn();
        step(1'b0, 1'b1, 8'hA6, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        idle(2);
        step(1'b0, 1'b1, 8'h1D, 1'b0);        // step 4
        idle(4);
        step(1'b1, 1'b0, '0, 1'b0);           // step 9: sync on last bit
        idle(11);
        exp_word(2, 8'hA6);
        exp_word(10, 8'h1D);
        check_stream("R11", 21);
        chk("R11", "no sync_err", lg_er[12], 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_delay(2'd0, 0, 8'hA5, "R2");
        t_delay(2'd1, 1, 8'h4B, "R3");
        t_delay(2'd2, 2, 8'hD2, "R3");
        t_delay(2'd3, 2, 8'h69, "R3");
        t_single_phase();
        t_dual_phase();
        t_abort(1'b1);
        t_abort(1'b0);
        t_ignore();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule